// File: doc/BRIEF.md
# SHA-224 Iterative Compression Core

This block hashes a message that has already been padded into 512-bit blocks, using the SHA-224 algorithm. It holds eight 32-bit chaining words and runs one compression round per clock. A block is accepted when the core is idle and `blk_valid` is high. The core then runs 64 rounds and one further cycle in which the working variables are added back into the chaining words. The round constants and the 16-word rolling message schedule are inside the block.

A message starts with a block that has `msg_init` set. That block loads the SHA-224 initial chaining values. Blocks without `msg_init` continue from the chaining words left by the previous block. When the block marked `blk_last` completes, `digest_valid` pulses for one cycle. At that point `digest` shows the first seven chaining words, with H0 in the top bits. The digest stays unchanged until another block is accepted.

Top module: `sha224_core`

## Requirements
- R1: After reset `busy` and `digest_valid` are 0.
- R2: The single padded block of the empty message (0x80 in the top byte, all other bits 0) with `msg_init` and `blk_last` set gives digest d14a028c2a3a2bc9476102bb288234c415a2b01f828ea62ac5b3e42f.
- R3: The padded block of "abc" (bytes 61 62 63 in the top 24 bits, then 0x80, zeros, and a 64-bit length of 24 in the low bits) gives digest 23097d223405d8228642a477bda255b32aadbce4bda0b3f7e36c9da7.
- R4: A two-block message produces the correct digest, with the chaining words carried from the first block into the second. The message is the 56-character string "abcdbcde...nopq", whose digest is 75388b16512776cc5dba5da1fd890150b0c6455cb4f58b1952522525.
- R5: After the clock edge that accepts a block, `busy` is high for exactly 65 cycles: 64 rounds and one final-add cycle.
- R6: `digest_valid` is a single-cycle pulse. It rises in the cycle `busy` falls, and only when the block just finished was marked `blk_last`. A non-last block produces no pulse.
- R7: `blk_valid` and the block inputs are ignored while `busy` is high, and the result is unaffected.
- R8: A block with `msg_init` set restarts the chaining words from the SHA-224 initial values, whatever message came before.
- R9: While the core is idle and no block is accepted, `digest` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| blk_valid | input | 1 | A block is offered; it is taken when the core is idle |
| msg_init | input | 1 | The offered block is the first block of a new message |
| blk_last | input | 1 | The offered block is the final block of the message |
| blk_data | input | 512 | Padded block; word 0 in bits 511:480 |
| busy | output | 1 | The core is compressing a block |
| digest | output | 224 | H0..H6, with H0 in bits 223:192 |
| digest_valid | output | 1 | One-cycle strobe when the last block has finished |

## Verification
A block is taken at one rising edge. `busy` is then high at the 65 falling edges that follow. At the next falling edge `busy` reads 0, `digest_valid` equals the block's last flag, and `digest` holds its final value. One falling edge after that, the strobe is back at 0. The bench drives inputs at falling edges and counts `busy` cycles from the accepting edge. It samples the digest and the strobe only at those computed falling edges. It also holds junk on the inputs for part of a busy window, to show that R7 holds at the outputs.

// File: rtl/sha224_core.sv
module sha224_core (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         blk_valid,
  input  logic         msg_init,
  input  logic         blk_last,
  input  logic [511:0] blk_data,
  output logic         busy,
  output logic [223:0] digest,
  output logic         digest_valid
);
  localparam int ROUNDS = 64;
  localparam int RW     = $clog2(ROUNDS) + 1;
  localparam logic [255:0] IV = {
    32'hc1059ed8, 32'h367cd507, 32'h3070dd17, 32'hf70e5939,
    32'hffc00b31, 32'h68581511, 32'h64f98fa7, 32'hbefa4fa4};

  function automatic logic [31:0] ror(input logic [31:0] x, input int n);
    return (x >> n) | (x << (32 - n));
  endfunction

  function automatic logic [31:0] kconst(input logic [5:0] i);
    case (i)
      6'd0:  return 32'h428a2f98;  6'd1:  return 32'h71374491;
      6'd2:  return 32'hb5c0fbcf;  6'd3:  return 32'he9b5dba5;
      6'd4:  return 32'h3956c25b;  6'd5:  return 32'h59f111f1;
      6'd6:  return 32'h923f82a4;  6'd7:  return 32'hab1c5ed5;
      6'd8:  return 32'hd807aa98;  6'd9:  return 32'h12835b01;
      6'd10: return 32'h243185be;  6'd11: return 32'h550c7dc3;
      6'd12: return 32'h72be5d74;  6'd13: return 32'h80deb1fe;
      6'd14: return 32'h9bdc06a7;  6'd15: return 32'hc19bf174;
      6'd16: return 32'he49b69c1;  6'd17: return 32'hefbe4786;
      6'd18: return 32'h0fc19dc6;  6'd19: return 32'h240ca1cc;
      6'd20: return 32'h2de92c6f;  6'd21: return 32'h4a7484aa;
      6'd22: return 32'h5cb0a9dc;  6'd23: return 32'h76f988da;
      6'd24: return 32'h983e5152;  6'd25: return 32'ha831c66d;
      6'd26: return 32'hb00327c8;  6'd27: return 32'hbf597fc7;
      6'd28: return 32'hc6e00bf3;  6'd29: return 32'hd5a79147;
      6'd30: return 32'h06ca6351;  6'd31: return 32'h14292967;
      6'd32: return 32'h27b70a85;  6'd33: return 32'h2e1b2138;
      6'd34: return 32'h4d2c6dfc;  6'd35: return 32'h53380d13;
      6'd36: return 32'h650a7354;  6'd37: return 32'h766a0abb;
      6'd38: return 32'h81c2c92e;  6'd39: return 32'h92722c85;
      6'd40: return 32'ha2bfe8a1;  6'd41: return 32'ha81a664b;
      6'd42: return 32'hc24b8b70;  6'd43: return 32'hc76c51a3;
      6'd44: return 32'hd192e819;  6'd45: return 32'hd6990624;
      6'd46: return 32'hf40e3585;  6'd47: return 32'h106aa070;
      6'd48: return 32'h19a4c116;  6'd49: return 32'h1e376c08;
      6'd50: return 32'h2748774c;  6'd51: return 32'h34b0bcb5;
      6'd52: return 32'h391c0cb3;  6'd53: return 32'h4ed8aa4a;
      6'd54: return 32'h5b9cca4f;  6'd55: return 32'h682e6ff3;
      6'd56: return 32'h748f82ee;  6'd57: return 32'h78a5636f;
      6'd58: return 32'h84c87814;  6'd59: return 32'h8cc70208;
      6'd60: return 32'h90befffa;  6'd61: return 32'ha4506ceb;
      6'd62: return 32'hbef9a3f7;  default: return 32'hc67178f2;
    endcase
  endfunction

  logic [31:0]   hv [8];
  logic [31:0]   wv [8];
  logic [31:0]   w  [16];
  logic [RW-1:0] rnd;
  logic          last_q;
  logic [31:0]   t1, t2, wnext;

  wire accept   = !busy && blk_valid;
  wire in_round = busy && (rnd != RW'(ROUNDS));

  always_comb begin
    t1 = wv[7] + (ror(wv[4], 6) ^ ror(wv[4], 11) ^ ror(wv[4], 25))
       + ((wv[4] & wv[5]) ^ (~wv[4] & wv[6])) + kconst(rnd[5:0]) + w[0];
    t2 = (ror(wv[0], 2) ^ ror(wv[0], 13) ^ ror(wv[0], 22))
       + ((wv[0] & wv[1]) ^ (wv[0] & wv[2]) ^ (wv[1] & wv[2]));
    wnext = (ror(w[14], 17) ^ ror(w[14], 19) ^ (w[14] >> 10)) + w[9]
          + (ror(w[1], 7) ^ ror(w[1], 18) ^ (w[1] >> 3)) + w[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy         <= 1'b0;
      digest_valid <= 1'b0;
      last_q       <= 1'b0;
      rnd          <= '0;
      for (int i = 0; i < 8; i++) begin
        hv[i] <= IV[255-32*i -: 32];
        wv[i] <= '0;
      end
      for (int j = 0; j < 16; j++) w[j] <= '0;
    end else begin
      digest_valid <= 1'b0;
      if (accept) begin
        busy   <= 1'b1;
        rnd    <= '0;
        last_q <= blk_last;
        for (int i = 0; i < 8; i++) begin
          wv[i] <= msg_init ? IV[255-32*i -: 32] : hv[i];
          if (msg_init) hv[i] <= IV[255-32*i -: 32];
        end
        for (int j = 0; j < 16; j++) w[j] <= blk_data[511-32*j -: 32];
      end else if (in_round) begin
        wv[0] <= t1 + t2;
        wv[1] <= wv[0];
        wv[2] <= wv[1];
        wv[3] <= wv[2];
        wv[4] <= wv[3] + t1;
        wv[5] <= wv[4];
        wv[6] <= wv[5];
        wv[7] <= wv[6];
        for (int j = 0; j < 15; j++) w[j] <= w[j+1];
        w[15] <= wnext;
        rnd   <= rnd + 1'b1;
      end else if (busy) begin
        for (int i = 0; i < 8; i++) hv[i] <= hv[i] + wv[i];
        busy         <= 1'b0;
        digest_valid <= last_q;
      end
    end
  end

  assign digest = {hv[0], hv[1], hv[2], hv[3], hv[4], hv[5], hv[6]};

  a_r5_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);
  a_r5_full_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(rnd) == RW'(ROUNDS));
  a_r7_no_early_exit: assert property (@(posedge clk) disable iff (!rst_n)
    in_round |=> busy);
  a_r6_strobe_idle: assert property (@(posedge clk) disable iff (!rst_n)
    digest_valid |-> !busy && $fell(busy));
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    digest_valid |=> !digest_valid);
  a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !blk_valid) |=> $stable(digest));
endmodule

// File: tb/sha224_core_bench.sv
module sha224_core_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 3;

  typedef struct packed {
    logic [1:0]   nblk;
    logic [511:0] b0;
    logic [511:0] b1;
    logic [223:0] exp;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{2'd1, {8'h80, 504'h0}, 512'h0,
      224'hd14a028c2a3a2bc9476102bb288234c415a2b01f828ea62ac5b3e42f},
    '{2'd1, {24'h616263, 8'h80, 416'h0, 64'd24}, 512'h0,
      224'h23097d223405d8228642a477bda255b32aadbce4bda0b3f7e36c9da7},
    '{2'd2, {"abcdbcdecdefdefgefghfghighijhijkijkljklmklmnlmnomnopnopq", 8'h80, 56'h0},
      {448'h0, 64'd448},
      224'h75388b16512776cc5dba5da1fd890150b0c6455cb4f58b1952522525}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic blk_valid = 1'b0, msg_init = 1'b0, blk_last = 1'b0;
  logic [511:0] blk_data = '0;
  logic busy, digest_valid;
  logic [223:0] digest;
  int tests = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sha224_core u_sha224_core (
    .clk(clk), .rst_n(rst_n), .blk_valid(blk_valid), .msg_init(msg_init),
    .blk_last(blk_last), .blk_data(blk_data), .busy(busy),
    .digest(digest), .digest_valid(digest_valid));

  task automatic check(input string req, input logic [223:0] act, input logic [223:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  task automatic send(input logic [511:0] d, input logic ini, input logic lst,
                      input int junk_cycles, input string req);
    int n = 0;
    @(negedge clk);
    blk_data = d; msg_init = ini; blk_last = lst; blk_valid = 1'b1;
    @(negedge clk);
    blk_valid = (junk_cycles > 0);
    blk_data = {16{32'hdeadbeef}}; msg_init = 1'b1; blk_last = ~lst;
    while (busy) begin
      n++;
      if (n >= junk_cycles) blk_valid = 1'b0;
      @(negedge clk);
    end
    blk_valid = 1'b0;
    check({req, " R5 busy length"}, 224'(n), 224'd65);
    check({req, " R6 strobe at end"}, 224'(digest_valid), 224'(lst));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    logic [223:0] held;
    repeat (3) @(negedge clk);
    check("R1 busy at reset", 224'(busy), 224'd0);
    check("R1 strobe at reset", 224'(digest_valid), 224'd0);
    rst_n = 1'b1;

    for (int v = 0; v < NVEC; v++) begin
      if (VECS[v].nblk == 2'd2) begin
        send(VECS[v].b0, 1'b1, 1'b0, 0, "R4 first block");
        send(VECS[v].b1, 1'b0, 1'b1, 0, "R4 second block");
        check("R4 two-block digest", digest, VECS[v].exp);
      end else begin
        send(VECS[v].b0, 1'b1, 1'b1, 0, v == 0 ? "R2" : "R3");
        check(v == 0 ? "R2 empty digest" : "R3 abc digest", digest, VECS[v].exp);
      end
      @(negedge clk);
      check("R6 strobe one cycle", 224'(digest_valid), 224'd0);
    end

    send(VECS[1].b0, 1'b1, 1'b1, 40, "R7");
    check("R7 junk while busy ignored", digest, VECS[1].exp);
    check("R8 init restarts chain", digest, VECS[1].exp);

    held = digest;
    repeat (10) @(negedge clk);
    check("R9 digest held idle", digest, held);
    check("R7 no extra block taken", 224'(busy), 224'd0);

    send(VECS[0].b0, 1'b1, 1'b1, 0, "R8");
    check("R8 init after abc", digest, VECS[0].exp);
    summary();
  end
endmodule